// File: doc/BRIEF.md
# Processor Reset Sequencer with Hard and Soft Reset

This block holds the architectural state that a small multi-cycle processor must bring to a known value on reset: the program counter, the control step counter and a bank of general-purpose registers. It accepts two reset requests with different reach. A start request performs a hard reset that clears the step counter, loads the program counter with a fixed start address and zeroes every general register. A reset request performs a soft reset that clears the step counter and reloads the program counter but keeps the register contents.

Outside reset, the step counter advances once per clock and returns to zero when the control logic signals the end of an instruction. The program counter takes a new value on a write enable. A soft request that arrives in the middle of an instruction is held and applied at the next instruction boundary, while a hard request acts at once and overrides everything else. A one-cycle status pulse reports each completed reset and its kind.

Top module: `cpu_reset_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `pc` = `PC_START`, `step` = 0, every general register 0, `rst_done` = 0, `rst_kind` = 2'b00 and `soft_wait` = 0.
- R2: Every hard or soft reset taken at a rising edge gives `step` = 0 and `pc` = `PC_START` from the following cycle on.
- R3: `start_req` high at a rising edge performs a hard reset, which also zeroes all general registers and cancels any waiting soft reset.
- R4: A soft reset leaves every general register unchanged.
- R5: A soft request is taken at once when `step` is 0, when `end_instr` is high, or when `step` is at its maximum (all ones); otherwise it is held, `soft_wait` reads 1, and it is taken at the first later edge that meets one of those conditions.
- R6: With no reset taken, `step` increases by one per clock, wraps from all ones to 0, and goes to 0 on any edge where `end_instr` is high.
- R7: When `start_req` and `soft_req` are high in the same cycle, a hard reset is performed and reported.
- R8: `pc_we` high loads `pc_wdata` into `pc` at the next edge, except in a cycle where a reset is taken, in which case `pc` becomes `PC_START`.
- R9: In the cycle after a reset is taken, `rst_done` is 1 for exactly that cycle and `rst_kind` is 2'b01 for hard or 2'b10 for soft; in all other cycles `rst_done` is 0 and `rst_kind` is 2'b00.
- R10: The register file has one write port (written at the edge when `rf_we` is high) and two combinational read ports; in a cycle where a reset is being taken both read ports return 0 and a write is discarded.
- R11: The start address loaded into `pc` is the parameter `PC_START`.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| start_req | input | 1 | Hard reset request |
| soft_req | input | 1 | Soft reset request |
| end_instr | input | 1 | Last step of the current instruction |
| pc_we | input | 1 | Program counter write enable |
| pc_wdata | input | XLEN | New program counter value |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | log2(NREGS) | Register file write index |
| rf_wdata | input | XLEN | Register file write data |
| rf_raddr_a | input | log2(NREGS) | Read port A index |
| rf_raddr_b | input | log2(NREGS) | Read port B index |
| rf_rdata_a | output | XLEN | Read port A data |
| rf_rdata_b | output | XLEN | Read port B data |
| pc | output | XLEN | Program counter |
| step | output | STEP_W | Control step counter |
| soft_wait | output | 1 | Soft reset held until instruction boundary |
| rst_done | output | 1 | One-cycle pulse after a reset |
| rst_kind | output | 2 | Kind of the reset just completed |

## Verification
The reset logic is driven with soft requests at step zero, mid-instruction, at the end-of-instruction input and at the counter's natural wrap, which separates immediate from deferred application and shows which boundary releases a held request. Start alone, start together with a soft request, and start over a held soft request tell hard priority and cancellation apart. Register contents written before a soft reset and then read back distinguish the two reset scopes, and reads and writes placed in the reset cycle itself show the port blocking.

// File: rtl/rst_ctrl_pkg.sv
// Shared types for the processor reset sequencer.
package rst_ctrl_pkg;

    // Reset kind reported on the status output.
    typedef enum logic [1:0] {
        RK_NONE = 2'b00,
        RK_HARD = 2'b01,
        RK_SOFT = 2'b10
    } rst_kind_e;

endpackage

// File: rtl/rst_seq.sv
// Reset sequencer: decides in each cycle whether a hard or a soft reset is
// taken, holds a soft request until an instruction boundary, and produces
// the one-cycle status pulse. Assumes requests are sampled synchronously.
module rst_seq
    import rst_ctrl_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              soft_req,
    input  logic              end_instr,
    input  logic [STEP_W-1:0] step,
    output logic              hard_now,
    output logic              soft_now,
    output logic              soft_wait,
    output logic              rst_done,
    output logic [1:0]        rst_kind
);

    localparam logic [STEP_W-1:0] STEP_MAX = '1;

    logic boundary;
    logic pend_q;

    // Instruction boundary: idle step, explicit end, or natural wrap.
    always_comb begin
        boundary = (step == '0) || end_instr || (step == STEP_MAX);
        hard_now = !rst_n || start_req;
        soft_now = rst_n && !start_req && (soft_req || pend_q) && boundary;
    end

    // Hold a soft request that arrived away from a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || start_req || soft_now)
            pend_q <= 1'b0;
        else if (soft_req)
            pend_q <= 1'b1;
    end

    // Status pulse and kind for the cycle after a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_done <= 1'b0;
            rst_kind <= RK_NONE;
        end else if (start_req) begin
            rst_done <= 1'b1;
            rst_kind <= RK_HARD;
        end else if (soft_now) begin
            rst_done <= 1'b1;
            rst_kind <= RK_SOFT;
        end else begin
            rst_done <= 1'b0;
            rst_kind <= RK_NONE;
        end
    end

    assign soft_wait = pend_q;

endmodule

// File: rtl/step_ctr.sv
// Control step counter: counts once per cycle, clears on end of
// instruction or on any reset. Assumes wrap at all ones is acceptable.
module step_ctr #(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              end_instr,
    output logic [STEP_W-1:0] step
);

    // Advance, or return to zero on reset or instruction end.
    always_ff @(posedge clk) begin
        if (clr || end_instr)
            step <= '0;
        else
            step <= step + 1'b1;
    end

endmodule

// File: rtl/pc_reg.sv
// Program counter register: loads the start address on reset, otherwise
// the write data when enabled. Assumes reset overrides any write.
module pc_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] PC_START = '0
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] pc
);

    // Reset reload or software write of the program counter.
    always_ff @(posedge clk) begin
        if (clr)
            pc <= PC_START;
        else if (we)
            pc <= wdata;
    end

endmodule

// File: rtl/gp_regfile.sv
// General register bank with one write and two read ports. A clear zeroes
// all entries; a block input masks reads and discards writes.
module gp_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            blk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);

    logic [XLEN-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // One entry: clear on hard reset, write when addressed and not blocked.
        always_ff @(posedge clk) begin
            if (clr)
                regs[g] <= '0;
            else if (we && !blk && (waddr == AW'(g)))
                regs[g] <= wdata;
        end
    end

    // Read ports return zero while blocked.
    always_comb begin
        rdata_a = blk ? '0 : regs[raddr_a];
        rdata_b = blk ? '0 : regs[raddr_b];
    end

endmodule

// File: rtl/cpu_reset_ctrl.sv
// Top of the reset sequencer: ties the decision logic to the step counter,
// program counter and register bank. A hard reset (start_req or rst_n low)
// clears all three; a soft reset reloads only counter and program counter.
module cpu_reset_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NREGS    = 32,
    parameter int              STEP_W   = 3,
    parameter logic [XLEN-1:0] PC_START = '0,
    localparam int             AW       = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              soft_req,
    input  logic              end_instr,
    input  logic              pc_we,
    input  logic [XLEN-1:0]   pc_wdata,
    input  logic              rf_we,
    input  logic [AW-1:0]     rf_waddr,
    input  logic [XLEN-1:0]   rf_wdata,
    input  logic [AW-1:0]     rf_raddr_a,
    input  logic [AW-1:0]     rf_raddr_b,
    output logic [XLEN-1:0]   rf_rdata_a,
    output logic [XLEN-1:0]   rf_rdata_b,
    output logic [XLEN-1:0]   pc,
    output logic [STEP_W-1:0] step,
    output logic              soft_wait,
    output logic              rst_done,
    output logic [1:0]        rst_kind
);

    logic hard_now;
    logic soft_now;
    logic any_rst;

    // Any reset taken in this cycle.
    assign any_rst = hard_now || soft_now;

    rst_seq #(.STEP_W(STEP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .soft_req  (soft_req),
        .end_instr (end_instr),
        .step      (step),
        .hard_now  (hard_now),
        .soft_now  (soft_now),
        .soft_wait (soft_wait),
        .rst_done  (rst_done),
        .rst_kind  (rst_kind)
    );

    step_ctr #(.STEP_W(STEP_W)) u_step (
        .clk       (clk),
        .clr       (any_rst),
        .end_instr (end_instr),
        .step      (step)
    );

    pc_reg #(.XLEN(XLEN), .PC_START(PC_START)) u_pc (
        .clk   (clk),
        .clr   (any_rst),
        .we    (pc_we),
        .wdata (pc_wdata),
        .pc    (pc)
    );

    gp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .clr     (hard_now),
        .blk     (any_rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rf_raddr_a),
        .raddr_b (rf_raddr_b),
        .rdata_a (rf_rdata_a),
        .rdata_b (rf_rdata_b)
    );

endmodule

// File: rtl/cpu_reset_ctrl_chk.sv
// Property checker for the reset sequencer, bound to its top module.
// Observes ports only; armed after the first edge with rst_n high.
module cpu_reset_ctrl_chk #(
    parameter int              XLEN     = 32,
    parameter int              STEP_W   = 3,
    parameter logic [XLEN-1:0] PC_START = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_req,
    input logic              soft_req,
    input logic              end_instr,
    input logic [XLEN-1:0]   rf_rdata_a,
    input logic [XLEN-1:0]   rf_rdata_b,
    input logic [XLEN-1:0]   pc,
    input logic [STEP_W-1:0] step,
    input logic              soft_wait,
    input logic              rst_done,
    input logic [1:0]        rst_kind
);

    localparam logic [STEP_W-1:0] STEP_MAX = '1;

    logic armed = 1'b0;

    // Marks that the previous edge saw rst_n high, so $past is meaningful.
    always_ff @(posedge clk) armed <= rst_n;

    // R3
    hard_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(start_req)) |-> (pc == PC_START && step == '0 &&
                                         rst_done && rst_kind == 2'b01 && !soft_wait));

    // R2
    soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && rst_kind == 2'b10) |-> (pc == PC_START && step == '0));

    // R7
    hard_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(start_req && soft_req)) |-> (rst_kind == 2'b01));

    // R9
    status_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |-> (rst_kind == 2'b01 || rst_kind == 2'b10));

    // R9
    status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_done |-> (rst_kind == 2'b00));

    // R10
    read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (rf_rdata_a == '0 && rf_rdata_b == '0));

    // R6
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !rst_done && !$past(end_instr)) |-> (step == STEP_W'($past(step) + 1'b1)));

    // R5
    soft_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(soft_req && !start_req && !end_instr &&
                        step != '0 && step != STEP_MAX)) |-> (!rst_done && soft_wait));

endmodule

bind cpu_reset_ctrl cpu_reset_ctrl_chk #(
    .XLEN(XLEN), .STEP_W(STEP_W), .PC_START(PC_START)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .soft_req   (soft_req),
    .end_instr  (end_instr),
    .rf_rdata_a (rf_rdata_a),
    .rf_rdata_b (rf_rdata_b),
    .pc         (pc),
    .step       (step),
    .soft_wait  (soft_wait),
    .rst_done   (rst_done),
    .rst_kind   (rst_kind)
);

// File: tb/tb_cpu_reset_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for counter wrap, deferred soft reset and register-file scope.
module tb_cpu_reset_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          XLEN       = 32;
    localparam int          NREGS      = 32;
    localparam int          STEP_W     = 3;
    localparam int          AW         = $clog2(NREGS);
    localparam logic [31:0] START      = 32'h0000_0100;
    localparam int          WDOG_MAX   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_req = 1'b0;
    logic              soft_req = 1'b0;
    logic              end_instr = 1'b0;
    logic              pc_we = 1'b0;
    logic [XLEN-1:0]   pc_wdata = '0;
    logic              rf_we = 1'b0;
    logic [AW-1:0]     rf_waddr = '0;
    logic [XLEN-1:0]   rf_wdata = '0;
    logic [AW-1:0]     rf_raddr_a = '0;
    logic [AW-1:0]     rf_raddr_b = '0;
    logic [XLEN-1:0]   rf_rdata_a;
    logic [XLEN-1:0]   rf_rdata_b;
    logic [XLEN-1:0]   pc;
    logic [STEP_W-1:0] step;
    logic              soft_wait;
    logic              rst_done;
    logic [1:0]        rst_kind;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    cpu_reset_ctrl #(
        .XLEN(XLEN), .NREGS(NREGS), .STEP_W(STEP_W), .PC_START(START)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .soft_req(soft_req),
        .end_instr(end_instr), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .pc(pc), .step(step), .soft_wait(soft_wait),
        .rst_done(rst_done), .rst_kind(rst_kind)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // One table row: inputs for one edge, expected outputs after it.
    typedef struct packed {
        logic        st;
        logic        sf;
        logic        eoi;
        logic        we;
        logic [31:0] wd;
        logic [31:0] e_pc;
        logic [2:0]  e_step;
        logic        e_done;
        logic [1:0]  e_kind;
        logic        e_wait;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 3'd1, 1'b0, 2'b00, 1'b0}, // R6 count
        '{1'b0, 1'b0, 1'b0, 1'b1, 32'h200, 32'h200, 3'd2, 1'b0, 2'b00, 1'b0}, // R8 load
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h200, 3'd3, 1'b0, 2'b00, 1'b0}, // R6
        '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0,   32'h200, 3'd0, 1'b0, 2'b00, 1'b0}, // R6 end
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h200, 3'd1, 1'b0, 2'b00, 1'b0}, // R6
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   32'h200, 3'd2, 1'b0, 2'b00, 1'b1}, // R5 held
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h200, 3'd3, 1'b0, 2'b00, 1'b1}, // R5 held
        '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0,   32'h100, 3'd0, 1'b1, 2'b10, 1'b0}, // R5 at end
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 3'd1, 1'b0, 2'b00, 1'b0}, // R9 pulse ends
        '{1'b0, 1'b0, 1'b0, 1'b1, 32'h300, 32'h300, 3'd2, 1'b0, 2'b00, 1'b0}, // R8
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 3'd0, 1'b1, 2'b01, 1'b0}, // R2 hard
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 3'd1, 1'b0, 2'b00, 1'b0}, // R9
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'h0,   32'h100, 3'd0, 1'b1, 2'b01, 1'b0}, // R7 prio
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   32'h100, 3'd0, 1'b1, 2'b10, 1'b0}, // R5 at step 0
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 3'd1, 1'b0, 2'b00, 1'b0}, // R6
        '{1'b0, 1'b1, 1'b0, 1'b1, 32'h400, 32'h400, 3'd2, 1'b0, 2'b00, 1'b1}, // R5 R8
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 3'd0, 1'b1, 2'b01, 1'b0}, // R3 cancel
        '{1'b1, 1'b0, 1'b0, 1'b1, 32'h500, 32'h100, 3'd0, 1'b1, 2'b01, 1'b0}  // R8 blocked
    };

    // Compare one value and log a failure line.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance one edge and settle past it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Clear all request and write inputs.
    task automatic idle_inputs();
        start_req = 1'b0;
        soft_req  = 1'b0;
        end_instr = 1'b0;
        pc_we     = 1'b0;
        pc_wdata  = '0;
        rf_we     = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_MAX && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG_MAX);
            report();
        end
    end

    initial begin
        // Power-on reset with writes attempted, which must not stick.
        rf_we    = 1'b1;
        rf_waddr = AW'(5);
        rf_wdata = 32'hDEAD_BEEF;
        repeat (2) tick();
        idle_inputs();
        rst_n      = 1'b1;
        rf_raddr_a = AW'(5);
        rf_raddr_b = AW'(9);
        #1;
        check("R1", "pc", pc, START);
        check("R11", "pc start param", pc, 32'h100);
        check("R1", "step", 32'(step), 0);
        check("R1", "done", 32'(rst_done), 0);
        check("R1", "kind", 32'(rst_kind), 0);
        check("R1", "wait", 32'(soft_wait), 0);
        check("R1", "reg5", rf_rdata_a, 0);
        check("R1", "reg9", rf_rdata_b, 0);

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            start_req = VECS[i].st;
            soft_req  = VECS[i].sf;
            end_instr = VECS[i].eoi;
            pc_we     = VECS[i].we;
            pc_wdata  = VECS[i].wd;
            tick();
            check($sformatf("R2/R5/R6/R8 row%0d", i), "pc", pc, VECS[i].e_pc);
            check($sformatf("R6 row%0d", i), "step", 32'(step), 32'(VECS[i].e_step));
            check($sformatf("R9 row%0d", i), "done", 32'(rst_done), 32'(VECS[i].e_done));
            check($sformatf("R9 row%0d", i), "kind", 32'(rst_kind), 32'(VECS[i].e_kind));
            check($sformatf("R5 row%0d", i), "wait", 32'(soft_wait), 32'(VECS[i].e_wait));
        end
        idle_inputs();

        // R6: natural wrap from all ones to zero.
        repeat (7) tick();
        check("R6", "step at max", 32'(step), 7);
        tick();
        check("R6", "step wrapped", 32'(step), 0);
        check("R6", "no pulse on wrap", 32'(rst_done), 0);

        // R5: held soft request released by the wrap.
        repeat (3) tick();
        soft_req = 1'b1;
        tick();
        soft_req = 1'b0;
        check("R5", "held mid-instr", 32'(soft_wait), 1);
        check("R5", "not yet applied", 32'(rst_done), 0);
        repeat (3) tick();
        check("R5", "step reached max", 32'(step), 7);
        check("R5", "still held", 32'(soft_wait), 1);
        tick();
        check("R5", "applied at wrap done", 32'(rst_done), 1);
        check("R5", "applied at wrap kind", 32'(rst_kind), 2);
        check("R5", "wait cleared", 32'(soft_wait), 0);

        // R10: write two registers and read them back.
        rf_we = 1'b1; rf_waddr = AW'(5); rf_wdata = 32'hA5A5_A5A5;
        tick();
        rf_waddr = AW'(9); rf_wdata = 32'h0000_1234;
        tick();
        rf_we = 1'b0;
        #1;
        check("R10", "read a", rf_rdata_a, 32'hA5A5_A5A5);
        check("R10", "read b", rf_rdata_b, 32'h0000_1234);

        // R10: soft reset cycle blocks reads and a write.
        soft_req = 1'b1; end_instr = 1'b1;
        rf_we = 1'b1; rf_waddr = AW'(5); rf_wdata = 32'hFFFF_FFFF;
        #1;
        check("R10", "blocked read a", rf_rdata_a, 0);
        check("R10", "blocked read b", rf_rdata_b, 0);
        tick();
        idle_inputs();
        #1;
        check("R9", "soft done", 32'(rst_kind), 2);
        check("R4", "reg5 kept, write dropped", rf_rdata_a, 32'hA5A5_A5A5);
        check("R4", "reg9 kept", rf_rdata_b, 32'h0000_1234);

        // R3: hard reset clears the bank; reads blocked in its cycle.
        start_req = 1'b1;
        #1;
        check("R10", "hard blocked read a", rf_rdata_a, 0);
        tick();
        idle_inputs();
        #1;
        check("R3", "reg5 cleared", rf_rdata_a, 0);
        check("R3", "reg9 cleared", rf_rdata_b, 0);
        check("R3", "pc", pc, START);

        if (!done) begin
            done = 1'b1;
            report();
        end
    end

endmodule